// File: doc/BRIEF.md
# Nine-Bit Multiprocessor Serial Receiver

This block deserialises asynchronous frames at a fixed bit rate set by the parameter `CLKS_PER_BIT`. In its wide format a frame is 11 bits long: a low start bit, eight data bits sent least significant bit first, a ninth bit and a high stop bit. The ninth bit tells the two kinds of frame apart. When it is 1 the frame carries a node address. When it is 0 the frame carries payload.

Several receivers can share one serial line. Each node sets `addr_only`, so that only address frames raise its receive flag and all payload traffic is dropped in hardware. Software compares each received address with the node's own. On a match it clears `addr_only` and then sees every frame. At the end of the message it sets `addr_only` again. A narrow 10-bit format with no ninth bit is also supported, and in that format the filter has no effect.

Top module: `mp_uart_rx`

## Requirements
- R1: The line idles high. A frame is a low start bit, the data bits least significant bit first, then (in wide format) the ninth bit, then a high stop bit, each lasting `CLKS_PER_BIT` clocks. When a frame is accepted, its eight data bits appear on `rx_data`.
- R2: With `mode_9bit`=1 and `addr_only`=0, every valid frame sets `rx_flag`, whatever its ninth bit.
- R3: With `mode_9bit`=1 and `addr_only`=1, a valid frame whose ninth bit is 1 sets `rx_flag` and loads `rx_data`.
- R4: With `mode_9bit`=1 and `addr_only`=1, a valid frame whose ninth bit is 0 leaves `rx_flag` low and leaves `rx_data` unchanged.
- R5: `rx_bit9` takes the received ninth bit on every valid wide frame, whether or not the flag is set.
- R6: If the line is high again at the middle of the start bit, the frame is abandoned: no flag is set and no output changes.
- R7: If the stop bit samples low, the frame is discarded: no flag is set and neither `rx_data` nor `rx_bit9` changes.
- R8: `rx_flag` stays set until a cycle with `flag_clr`=1. A flag set and a clear in the same cycle leave the flag set.
- R9: With `mode_9bit`=0 the frame has eight data bits and no ninth bit. Every valid frame sets the flag whatever `addr_only` is, and `rx_bit9` reads 0.
- R10: After reset, `rx_flag`, `rx_data` and `rx_bit9` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial receive line, idle high |
| mode_9bit | input | 1 | 1 selects the 11-bit format, 0 selects the 10-bit format |
| addr_only | input | 1 | Address filter enable: in the wide format, only frames whose ninth bit is 1 set the flag |
| flag_clr | input | 1 | Clears `rx_flag` |
| rx_data | output | 8 | Data byte of the last accepted frame |
| rx_bit9 | output | 1 | Ninth bit of the last valid frame |
| rx_flag | output | 1 | Receive-complete flag (the interrupt) |

## Verification
The bench sends a payload frame while the filter is on, right after an accepted address frame. A design that stored the byte on every frame would overwrite `rx_data`, and one that did not latch the ninth bit would leave `rx_bit9` stale. A short low glitch and a frame with a low stop bit are also sent. A receiver without the mid-start check or the stop check would report a spurious byte. The bench holds the clear input high across a whole frame, so a design that let the clear win the set cycle would never show the flag. A narrow frame is sent with the filter still on, so a design that applied the filter to that format would swallow it.

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       mode_9bit,
  input  logic       addr_only,
  input  logic       flag_clr,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       rx_flag
);
  localparam int CW   = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 2;
  localparam int HALF = CLKS_PER_BIT / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_BREAK} st_t;

  st_t          st;
  logic [1:0]   rx_s;
  logic [CW-1:0] cnt;
  logic [3:0]   bitn;
  logic [8:0]   sh;
  logic         wide_q;

  wire line     = rx_s[1];
  wire tick     = (cnt == CW'(CLKS_PER_BIT - 1));
  wire mid      = (cnt == CW'(HALF - 1));
  wire last_bit = (bitn == (wide_q ? 4'd8 : 4'd7));
  wire frame_ok = (st == S_STOP) && tick && line;
  wire accept   = frame_ok && (!wide_q || !addr_only || sh[8]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s   <= 2'b11;
      st     <= S_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      wide_q <= 1'b1;
    end else begin
      rx_s <= {rx_s[0], rxd};
      case (st)
        S_IDLE: if (!line) begin
          st     <= S_START;
          cnt    <= '0;
          wide_q <= mode_9bit;
        end
        S_START: if (mid) begin
          cnt  <= '0;
          bitn <= '0;
          st   <= line ? S_IDLE : S_DATA;
        end else cnt <= cnt + 1'b1;
        S_DATA: if (tick) begin
          cnt <= '0;
          sh  <= {line, sh[8:1]};
          if (last_bit) st <= S_STOP;
          else bitn <= bitn + 1'b1;
        end else cnt <= cnt + 1'b1;
        S_STOP: if (tick) begin
          cnt <= '0;
          st  <= line ? S_IDLE : S_BREAK;
        end else cnt <= cnt + 1'b1;
        S_BREAK: if (line) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_bit9 <= 1'b0;
      rx_flag <= 1'b0;
    end else begin
      if (frame_ok) rx_bit9 <= wide_q & sh[8];
      if (accept)   rx_data <= wide_q ? sh[7:0] : sh[8:1];
      if (accept)        rx_flag <= 1'b1;
      else if (flag_clr) rx_flag <= 1'b0;
    end
  end

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag && !flag_clr |=> rx_flag); // R8
  AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    accept && flag_clr |=> rx_flag); // R8
  AST_DATA_ONLY_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_flag); // R4
  AST_FILTER_ADDR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) && $past(addr_only) && $past(wide_q) |-> rx_bit9); // R3
  AST_NARROW_NO_BIT9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) && !$past(wide_q) |-> !rx_bit9); // R9
endmodule

// File: tb/sim_mp_uart_rx.sv
module sim_mp_uart_rx;
  localparam int CPB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic mode_9bit = 1'b1;
  logic addr_only = 1'b0;
  logic flag_clr = 1'b0;
  logic [7:0] rx_data;
  logic rx_bit9;
  logic rx_flag;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] data;
    logic       bit9;
    logic       flag;
    string      tag;
  } exp_t;

  exp_t q[$];

  always #2 clk = ~clk;

  mp_uart_rx #(.CLKS_PER_BIT(CPB)) u0 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .mode_9bit(mode_9bit),
    .addr_only(addr_only), .flag_clr(flag_clr),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_flag(rx_flag));

  task automatic chk(input string tag, input int got, input int expv);
    checks++;
    if (got != expv) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, expv);
    end
  endtask

  task automatic drive_bit(input logic v);
    rxd = v;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic stop);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (mode_9bit) drive_bit(b9);
    drive_bit(stop);
    rxd = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d, input logic b9, input logic f, input string tag);
    exp_t e;
    e.data = d; e.bit9 = b9; e.flag = f; e.tag = tag;
    q.push_back(e);
    wait (q.size() == 0);
  endtask

  initial begin : monitor
    forever begin
      exp_t e;
      wait (q.size() != 0);
      @(negedge clk);
      e = q[0];
      chk({e.tag, " data"}, rx_data, e.data);
      chk({e.tag, " bit9"}, rx_bit9, e.bit9);
      chk({e.tag, " flag"}, rx_flag, e.flag);
      if (e.flag) begin
        repeat (20) @(negedge clk);
        chk("R8 flag sticky", rx_flag, 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
        chk("R8 flag cleared", rx_flag, 0);
      end
      void'(q.pop_front());
    end
  end

  int seen = 0;
  always @(negedge clk) if (rx_flag) seen++;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    chk("R10 flag", rx_flag, 0);
    chk("R10 data", rx_data, 0);
    chk("R10 bit9", rx_bit9, 0);
    rst_n = 1'b1;
    repeat (2 * CPB) @(negedge clk);

    addr_only = 1'b0;
    send(8'hA5, 1'b0, 1'b1); push(8'hA5, 1'b0, 1'b1, "R1/R2 data frame, filter off");
    send(8'h3C, 1'b1, 1'b1); push(8'h3C, 1'b1, 1'b1, "R2 address frame, filter off");

    addr_only = 1'b1;
    send(8'h5A, 1'b1, 1'b1); push(8'h5A, 1'b1, 1'b1, "R3 address frame, filter on");
    send(8'h81, 1'b0, 1'b1); push(8'h5A, 1'b0, 1'b0, "R4/R5 data frame dropped");
    send(8'hFF, 1'b1, 1'b0); push(8'h5A, 1'b0, 1'b0, "R7 stop low");

    rxd = 1'b0;
    repeat (CPB / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * CPB) @(negedge clk);
    push(8'h5A, 1'b0, 1'b0, "R6 false start");

    addr_only = 1'b0;
    send(8'h66, 1'b0, 1'b1); push(8'h66, 1'b0, 1'b1, "R2 filter cleared");
    addr_only = 1'b1;
    send(8'h77, 1'b0, 1'b1); push(8'h66, 1'b0, 1'b0, "R4 filter set again");

    addr_only = 1'b0;
    seen = 0;
    flag_clr = 1'b1;
    send(8'h12, 1'b1, 1'b1);
    flag_clr = 1'b0;
    chk("R8 set beats clear", (seen > 0) ? 1 : 0, 1);
    chk("R8 flag cleared after hold", rx_flag, 0);

    mode_9bit = 1'b0;
    addr_only = 1'b1;
    send(8'hC3, 1'b0, 1'b1); push(8'hC3, 1'b0, 1'b1, "R9 narrow frame, filter on");
    send(8'h0F, 1'b0, 1'b1); push(8'h0F, 1'b0, 1'b1, "R9 narrow frame again");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule